// File: doc/BRIEF.md
# Bank conflict resolver for a banked scratchpad

This block sits in front of a scratchpad made of 32 banks, each holding 32-bit words, and owns the bank arrays itself. In one cycle a requester hands it a group of word requests, one slot per lane. Each lane may be enabled or not, and each enabled lane is either a read or a write. The bank of a word is the low five bits of its word address, so words whose addresses differ by a multiple of 32 share a bank.

The resolver replays the group over as few cycles as possible. In each replay cycle every bank serves at most one lane. Among the lanes that are still waiting on a bank, the lowest-numbered one is served first. The number of replay cycles equals the conflict degree, which is the largest number of enabled lanes that map to any one bank. The block reports that degree. It holds a stall output high while it is busy. When the last read has returned, it presents the read words of all lanes together with a one-cycle valid pulse.

A requester presents a group while stall is low and then waits for the valid pulse. Two access patterns need no replay at all: stride-1 patterns and one-to-one permutations of lanes onto banks. Column walks through a row pitch of 33 words also need no replay, while a pitch of 32 puts every lane in the same bank.

Top module: `bank_conflict_resolver`

## Requirements
- R1: The bank of a lane is bits [4:0] of its word address and the row inside the bank is bits [8:5]. Thirty-two lanes reading consecutive word addresses give a conflict degree of 1 and return the stored words.
- R2: Any group in which the enabled lanes map one-to-one onto distinct banks has a conflict degree of 1.
- R3: `conflict_degree` equals the largest count of enabled lanes sharing one bank. Lanes that name the same word count separately. The value appears in the cycle after acceptance and holds until the next acceptance.
- R4: After the acceptance cycle, `stall` is high for exactly degree+1 cycles: one cycle per replay plus one read-return cycle. `rsp_valid` is high for exactly one cycle, the first cycle in which `stall` is low again.
- R5: With 32 lanes, word stride 2 gives degree 2 and word stride 8 gives degree 8. With 16 lanes walking a column, a row pitch of 32 words gives degree 16 and a pitch of 33 words gives degree 1.
- R6: Lanes that share a bank are served in ascending lane order. A read from a higher lane sees a write by a lower lane to the same word in the same group, and a read from a lower lane sees the older value.
- R7: While `rsp_valid` is high, slot k of `rsp_rdata` (bits [32k+31:32k]) holds the word read by lane k. It holds 0 for lanes that wrote or were not enabled.
- R8: A group is taken only when `req_valid` is high and `stall` is low. A group presented while `stall` is high writes nothing and leaves `conflict_degree` unchanged.
- R9: A group with no enabled lane reports degree 0, stalls for one cycle and then pulses `rsp_valid` with all slots 0.
- R10: After reset, `stall`, `rsp_valid` and `conflict_degree` are 0. An enabled lane with its write bit set stores its 32-bit data word at its word address, and a later read returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request group is presented |
| req_lane_en | input | 32 | Per-lane enable |
| req_lane_we | input | 32 | Per-lane write select (1 = write, 0 = read) |
| req_addr | input | 288 | Per-lane 9-bit word address, lane k at bits [9k+8:9k] |
| req_wdata | input | 1024 | Per-lane write word, lane k at bits [32k+31:32k] |
| stall | output | 1 | Group in progress; new groups are not taken |
| conflict_degree | output | 6 | Degree of the most recent group |
| rsp_valid | output | 1 | One-cycle pulse: all read words are present |
| rsp_rdata | output | 1024 | Per-lane read word, lane k at bits [32k+31:32k] |

## Verification
Some internal faults change the replay count, such as a lane bit that is never cleared, or one cleared without being served. These show at once in the length of the stall window and in the position of the valid pulse, at the end of the same group. A picker that serves lanes out of order, or a read-return path that routes a bank word to the wrong lane, shows up as wrong words in the response of that group. A wrong write slips through unnoticed until a later group reads the word. The bench therefore fills the whole scratchpad first and keeps a word-level model, so any corrupted word surfaces at its next read.

// File: rtl/bcr_pkg.sv
// Shared defaults and helpers for the bank conflict resolver.
// Assumes every size below is a power of two.
package bcr_pkg;
    localparam int unsigned BCR_LANES_DEF = 32;
    localparam int unsigned BCR_BANKS_DEF = 32;
    localparam int unsigned BCR_DEPTH_DEF = 16;
    localparam int unsigned BCR_DATA_DEF  = 32;

    // Bits needed to hold any count from 0 up to n inclusive.
    function automatic int unsigned count_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/bcr_lane_pick.sv
// Per-bank picker: among the pending lanes that map to bank BANK_ID it
// grants the lowest-numbered one. The output is one-hot or all zero.
// Assumes lane_bank carries BANK_BITS bits per lane, lane 0 lowest.
module bcr_lane_pick #(
    parameter int NUM_LANES = 32,
    parameter int BANK_BITS = 5,
    parameter int BANK_ID   = 0
) (
    input  logic [NUM_LANES-1:0]           pending,
    input  logic [NUM_LANES*BANK_BITS-1:0] lane_bank,
    output logic [NUM_LANES-1:0]           grant
);
    logic [NUM_LANES-1:0] match;

    // Mark the pending lanes whose bank index equals this bank.
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            match[l] = pending[l] &&
                       (lane_bank[l*BANK_BITS +: BANK_BITS] == BANK_BITS'(BANK_ID));
        end
    end

    // Isolate the lowest set bit: lower lane wins.
    assign grant = match & (~match + NUM_LANES'(1));
endmodule

// File: rtl/bcr_degree_calc.sv
// Conflict degree: the largest number of enabled lanes sharing one bank.
// Purely combinational; evaluated on the incoming group at acceptance.
module bcr_degree_calc #(
    parameter int NUM_LANES = 32,
    parameter int NUM_BANKS = 32,
    parameter int BANK_BITS = 5,
    parameter int DEG_W     = 6
) (
    input  logic [NUM_LANES-1:0]           lane_en,
    input  logic [NUM_LANES*BANK_BITS-1:0] lane_bank,
    output logic [DEG_W-1:0]               degree
);
    // Count lanes per bank and keep the running maximum.
    always_comb begin
        logic [DEG_W-1:0] cnt;
        degree = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            cnt = '0;
            for (int l = 0; l < NUM_LANES; l++) begin
                if (lane_en[l] &&
                    lane_bank[l*BANK_BITS +: BANK_BITS] == BANK_BITS'(b)) begin
                    cnt = cnt + DEG_W'(1);
                end
            end
            if (cnt > degree) degree = cnt;
        end
    end
endmodule

// File: rtl/bcr_bank_ram.sv
// One scratchpad bank: single port, synchronous write, registered read.
// Assumes DEPTH == 2**ROW_BITS. Contents are not reset.
module bcr_bank_ram #(
    parameter int DEPTH    = 16,
    parameter int ROW_BITS = 4,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                en,
    input  logic                we,
    input  logic [ROW_BITS-1:0] row,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Perform one access per enabled cycle; a read lands on rdata next cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[row] <= wdata;
            else    rdata    <= mem[row];
        end
    end
endmodule

// File: rtl/bank_conflict_resolver.sv
// Bank conflict resolver. Takes a group of per-lane word requests when
// stall is low, replays it so each bank sees one lane per cycle (lowest
// lane first), and returns all read words together with rsp_valid.
// Assumes power-of-two bank count and bank depth, and at least two lanes.
module bank_conflict_resolver
    import bcr_pkg::*;
#(
    parameter  int NUM_LANES  = BCR_LANES_DEF,
    parameter  int NUM_BANKS  = BCR_BANKS_DEF,
    parameter  int BANK_DEPTH = BCR_DEPTH_DEF,
    parameter  int DATA_W     = BCR_DATA_DEF,
    localparam int BANK_BITS  = $clog2(NUM_BANKS),
    localparam int ROW_BITS   = $clog2(BANK_DEPTH),
    localparam int ADDR_W     = BANK_BITS + ROW_BITS,
    localparam int LANE_BITS  = $clog2(NUM_LANES),
    localparam int DEG_W      = count_width(NUM_LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [NUM_LANES-1:0]        req_lane_en,
    input  logic [NUM_LANES-1:0]        req_lane_we,
    input  logic [NUM_LANES*ADDR_W-1:0] req_addr,
    input  logic [NUM_LANES*DATA_W-1:0] req_wdata,
    output logic                        stall,
    output logic [DEG_W-1:0]            conflict_degree,
    output logic                        rsp_valid,
    output logic [NUM_LANES*DATA_W-1:0] rsp_rdata
);
    logic [NUM_LANES-1:0]           pend_q, served, we_q;
    logic [ADDR_W-1:0]              addr_q  [NUM_LANES];
    logic [DATA_W-1:0]              wdata_q [NUM_LANES];
    logic [DATA_W-1:0]              rd_q    [NUM_LANES];
    logic [DEG_W-1:0]               degree_q, degree_in;
    logic                           last_q, rsp_q, busy, accept;
    logic [NUM_LANES*BANK_BITS-1:0] req_bank, lane_bank;
    logic [NUM_LANES-1:0]           grant     [NUM_BANKS];
    logic [NUM_BANKS-1:0]           bank_en, bank_we, rdv_q;
    logic [LANE_BITS-1:0]           bank_lane [NUM_BANKS];
    logic [LANE_BITS-1:0]           rdl_q     [NUM_BANKS];
    logic [DATA_W-1:0]              bank_rd   [NUM_BANKS];

    assign busy   = |pend_q;
    assign stall  = busy | last_q;
    assign accept = req_valid & ~stall;

    // Extract the bank field of incoming and of held lane addresses.
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            req_bank[l*BANK_BITS +: BANK_BITS]  = req_addr[l*ADDR_W +: BANK_BITS];
            lane_bank[l*BANK_BITS +: BANK_BITS] = addr_q[l][BANK_BITS-1:0];
        end
    end

    bcr_degree_calc #(
        .NUM_LANES(NUM_LANES), .NUM_BANKS(NUM_BANKS),
        .BANK_BITS(BANK_BITS), .DEG_W(DEG_W)
    ) u_degree (
        .lane_en(req_lane_en), .lane_bank(req_bank), .degree(degree_in)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ROW_BITS-1:0]  row_sel;
        logic [DATA_W-1:0]    wd_sel;
        logic [LANE_BITS-1:0] lane_sel;
        logic                 we_sel;

        bcr_lane_pick #(
            .NUM_LANES(NUM_LANES), .BANK_BITS(BANK_BITS), .BANK_ID(b)
        ) u_pick (
            .pending(pend_q), .lane_bank(lane_bank), .grant(grant[b])
        );

        // Steer the granted lane's row, data and direction onto this bank.
        always_comb begin
            row_sel  = '0;
            wd_sel   = '0;
            lane_sel = '0;
            we_sel   = 1'b0;
            for (int l = 0; l < NUM_LANES; l++) begin
                if (grant[b][l]) begin
                    row_sel  = row_sel  | addr_q[l][ADDR_W-1:BANK_BITS];
                    wd_sel   = wd_sel   | wdata_q[l];
                    lane_sel = lane_sel | LANE_BITS'(l);
                    we_sel   = we_sel   | we_q[l];
                end
            end
        end

        assign bank_en[b]   = |grant[b];
        assign bank_we[b]   = we_sel;
        assign bank_lane[b] = lane_sel;

        bcr_bank_ram #(
            .DEPTH(BANK_DEPTH), .ROW_BITS(ROW_BITS), .DATA_W(DATA_W)
        ) u_ram (
            .clk(clk), .en(bank_en[b]), .we(we_sel), .row(row_sel),
            .wdata(wd_sel), .rdata(bank_rd[b])
        );
    end

    // Collect which lanes some bank served this cycle.
    always_comb begin
        served = '0;
        for (int b = 0; b < NUM_BANKS; b++) served = served | grant[b];
    end

    // Control: pending lanes, final-cycle flag, response pulse, degree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            last_q   <= 1'b0;
            rsp_q    <= 1'b0;
            degree_q <= '0;
            rdv_q    <= '0;
        end else begin
            rsp_q <= last_q;
            rdv_q <= bank_en & ~bank_we;
            if (accept) begin
                pend_q   <= req_lane_en;
                degree_q <= degree_in;
                last_q   <= ~|req_lane_en;
            end else begin
                pend_q <= pend_q & ~served;
                last_q <= busy && ((pend_q & ~served) == '0);
            end
        end
    end

    // Hold the accepted group's addresses, directions and write data.
    always_ff @(posedge clk) begin
        if (accept) begin
            we_q <= req_lane_we;
            for (int l = 0; l < NUM_LANES; l++) begin
                addr_q[l]  <= req_addr[l*ADDR_W +: ADDR_W];
                wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
            end
        end
    end

    // Remember which lane each bank read for, to route the word back.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) rdl_q[b] <= bank_lane[b];
    end

    // Response words: cleared on acceptance, filled as bank reads return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LANES; l++) rd_q[l] <= '0;
        end else begin
            if (accept) begin
                for (int l = 0; l < NUM_LANES; l++) rd_q[l] <= '0;
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (rdv_q[b]) rd_q[rdl_q[b]] <= bank_rd[b];
            end
        end
    end

    // Flatten the per-lane response words onto the output port.
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) rsp_rdata[l*DATA_W +: DATA_W] = rd_q[l];
    end

    assign rsp_valid       = rsp_q;
    assign conflict_degree = degree_q;

    // A taken group raises stall in the following cycle.
    assert_accept_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> stall);

    // The response is a single-cycle pulse.
    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // The response comes in the first cycle after stall falls.
    assert_rsp_after_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!stall && $past(stall)));

    // Every replay cycle serves at least one waiting lane.
    assert_replay_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(pend_q) < $past($countones(pend_q))));

    // The degree holds while a group is in flight.
    assert_degree_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(conflict_degree));

    // No lane becomes pending unless a group was taken.
    assert_no_new_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: tb/bank_conflict_resolver_bench.sv
module bank_conflict_resolver_bench;
    localparam int NL = 32;
    localparam int DW = 32;
    localparam int AW = 9;
    localparam int WORDS = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic [NL-1:0]    req_lane_en = '0, req_lane_we = '0;
    logic [NL*AW-1:0] req_addr = '0;
    logic [NL*DW-1:0] req_wdata = '0;
    logic             stall, rsp_valid;
    logic [5:0]       conflict_degree;
    logic [NL*DW-1:0] rsp_rdata;

    bank_conflict_resolver u_bank_conflict_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_lane_en(req_lane_en), .req_lane_we(req_lane_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall),
        .conflict_degree(conflict_degree), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    logic [DW-1:0] model [WORDS];
    logic [NL-1:0] t_en, t_we;
    logic [AW-1:0] t_addr [NL];
    logic [DW-1:0] t_wd [NL];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_degree();
        int cnt [32];
        int mx = 0;
        for (int b = 0; b < 32; b++) cnt[b] = 0;
        for (int l = 0; l < NL; l++) if (t_en[l]) cnt[t_addr[l][4:0]]++;
        for (int b = 0; b < 32; b++) if (cnt[b] > mx) mx = cnt[b];
        return mx;
    endfunction

    task automatic clear_group();
        t_en = '0;
        t_we = '0;
        for (int l = 0; l < NL; l++) begin
            t_addr[l] = '0;
            t_wd[l]   = '0;
        end
    endtask

    task automatic run_group(input string req, input bit inject);
        int deg;
        int n;
        int bad;
        logic [DW-1:0] exp_rd [NL];
        deg = exp_degree();
        for (int l = 0; l < NL; l++) begin
            exp_rd[l] = '0;
            if (t_en[l]) begin
                if (t_we[l]) model[t_addr[l]] = t_wd[l];
                else         exp_rd[l] = model[t_addr[l]];
            end
        end
        @(negedge clk);
        req_lane_en = t_en;
        req_lane_we = t_we;
        for (int l = 0; l < NL; l++) begin
            req_addr[l*AW +: AW]  = t_addr[l];
            req_wdata[l*DW +: DW] = t_wd[l];
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (stall === 1'b1 && n < 200) begin
            if (n == 0) chk(conflict_degree == 6'(deg), req, "R3 degree", conflict_degree, deg);
            if (inject && n == 1) req_valid = 1'b0;
            if (inject && n == 0) begin
                req_valid   = 1'b1;
                req_lane_en = '1;
                req_lane_we = '1;
                for (int l = 0; l < NL; l++) begin
                    req_addr[l*AW +: AW]  = AW'(l);
                    req_wdata[l*DW +: DW] = 32'hBAD0_0000 + l;
                end
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(n == deg + 1, req, "R4 stall cycles", n, deg + 1);
        chk(rsp_valid == 1'b1, req, "R4 rsp_valid after stall", rsp_valid, 1);
        chk(conflict_degree == 6'(deg), req, "R3 degree held", conflict_degree, deg);
        bad = -1;
        for (int l = NL - 1; l >= 0; l--) if (rsp_rdata[l*DW +: DW] !== exp_rd[l]) bad = l;
        if (bad < 0) chk(1'b1, req, "R7 data", 0, 0);
        else chk(1'b0, req, $sformatf("R7 data lane %0d", bad),
                 rsp_rdata[bad*DW +: DW], exp_rd[bad]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(stall == 1'b0, "R10", "reset stall", stall, 0);
        chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", rsp_valid, 0);
        chk(conflict_degree == 6'd0, "R10", "reset degree", conflict_degree, 0);
        rst_n = 1'b1;

        // R10: fill every word, stride-1 write groups
        for (int g = 0; g < 16; g++) begin
            clear_group();
            for (int l = 0; l < NL; l++) begin
                t_en[l] = 1'b1; t_we[l] = 1'b1;
                t_addr[l] = AW'(g * 32 + l); t_wd[l] = $urandom;
            end
            run_group("R10", 1'b0);
        end
        // R1: stride-1 read
        clear_group();
        for (int l = 0; l < NL; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(64 + l); end
        run_group("R1", 1'b0);
        // R2: one-to-one permutation onto banks
        clear_group();
        for (int l = 0; l < NL; l++) begin
            t_en[l] = 1'b1; t_addr[l] = AW'(((l * 7) % 32) + 32 * (l % 16));
        end
        run_group("R2", 1'b0);
        // R5: stride 2 and stride 8
        clear_group();
        for (int l = 0; l < NL; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(2 * l); end
        run_group("R5", 1'b0);
        clear_group();
        for (int l = 0; l < NL; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(8 * l); end
        run_group("R5", 1'b0);
        // R5: column walk, pitch 32 versus padded pitch 33
        clear_group();
        for (int l = 0; l < 16; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(32 * l + 3); end
        run_group("R5", 1'b0);
        clear_group();
        for (int l = 0; l < 16; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(33 * l); end
        run_group("R5", 1'b0);
        // R6: lane order inside a bank
        clear_group();
        t_en[0] = 1'b1; t_we[0] = 1'b1; t_addr[0] = 9'd100; t_wd[0] = 32'hA5A5_0001;
        t_en[1] = 1'b1; t_addr[1] = 9'd100;
        t_en[2] = 1'b1; t_addr[2] = 9'd200;
        t_en[3] = 1'b1; t_we[3] = 1'b1; t_addr[3] = 9'd200; t_wd[3] = 32'h5A5A_0002;
        run_group("R6", 1'b0);
        clear_group();
        t_en[5] = 1'b1; t_addr[5] = 9'd200;
        run_group("R6", 1'b0);
        // R9: empty group
        clear_group();
        run_group("R9", 1'b0);
        // R8: group presented during stall is ignored
        clear_group();
        for (int l = 0; l < NL; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(8 * l + 1); end
        run_group("R8", 1'b1);
        clear_group();
        for (int l = 0; l < NL; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(l); end
        run_group("R8", 1'b0);
        // R3: random groups, mixed reads and writes
        for (int g = 0; g < 40; g++) begin
            clear_group();
            for (int l = 0; l < NL; l++) begin
                t_en[l]   = ($urandom % 4) != 0;
                t_we[l]   = ($urandom % 4) == 0;
                t_addr[l] = (g % 2 == 0) ? AW'($urandom % 64) : AW'($urandom % WORDS);
                t_wd[l]   = $urandom;
            end
            run_group("R3", 1'b0);
        end
        // R10: read back a region touched by random writes
        clear_group();
        for (int l = 0; l < NL; l++) begin t_en[l] = 1'b1; t_addr[l] = AW'(32 + l); end
        run_group("R10", 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule